// File: doc/BRIEF.md
# Peripheral DMA Channel

A single DMA channel that copies 32-bit words between a memory-side port and a peripheral-side port. Software programs it through a small register window: a control word, a status word, a memory pointer, a peripheral pointer and one sequence word per side. Setting the enable bit starts a pass. Each word is a read on the source side followed by a write on the destination side. Both pointers advance by four bytes after every word. The direction bit in the control word picks which side is the source.

A pass moves the programmed count plus one words. At the end of a pass the channel raises an end-of-count pending flag. In run-once mode it then stops. Otherwise it restarts from shadow copies of the pointers and the count, so software can queue the next buffer while the current one drains. The split (double-buffer) mode treats the programmed count as half a buffer. It flags the midpoint and the end, shows which half is running, and reloads the shadows only after both halves. With flow control set, a word waits for the selected peripheral request line. A global enable input freezes all activity so that the remaining count can be read while it holds still.

Top module: `dma_chan`

## Requirements
- R1: Each word is one source read followed by one destination write carrying the same data. Control bit 28 set means memory is the source and the peripheral is the destination; clear means the reverse. Both pointers advance by 4 after each word, and the two sides are never requested in the same cycle.
- R2: The count field (control bits 15:2) holds the number of words minus one. A pass moves count+1 words, and status bits 15:2 show the remaining words minus one.
- R3: With run-once (control bit 27) set, the channel stops after count+1 words. Busy (status bit 31) drops and control bit 31 reads back as zero.
- R4: Status bit 30 sets at the end of every pass or half. Writing the status register with bit 30 set clears it, and a pass end in the same cycle wins over the clear.
- R5: The interrupt output equals status bit 30 ANDed with control bit 30.
- R6: Without run-once, the channel restarts at the end of a pass from the shadow pointers and the shadow count. Pointer and count writes made during a pass do not change that pass.
- R7: With memory-sequence bit 19 set (split mode), the count covers half a buffer. Status bit 28 reads 0 in the first half and 1 in the second. Each half end sets status bit 30, and the shadows are loaded only after the second half.
- R8: While the global enable input is low, neither side is requested and the remaining count stays unchanged. Status bit 29 reads busy ANDed with the global enable being low. Activity resumes when the input returns high.
- R9: With flow control (control bit 21) set, a source read is issued only while the request line chosen by control bits 20:16 is high. Other request lines have no effect.
- R10: Pointer registers (index 2 memory, index 3 peripheral) store written values with bits 1:0 forced to zero, and every issued address is word aligned.
- R11: Writing the control word with bit 31 clear stops the channel at once. Busy and status bit 28 read zero on the next cycle.
- R12: After reset, every register reads zero, no side is requested and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Write register index (0 control, 1 status, 2 mem ptr, 3 per ptr, 4 mem seq, 5 per seq) |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 3 | Read register index |
| reg_rdata_o | output | 32 | Read data, combinational |
| gen_en_i | input | 1 | Global enable; low freezes the channel |
| dreq_i | input | NREQ | Peripheral request lines |
| mem_req_o | output | 1 | Memory-side access request |
| mem_we_o | output | 1 | Memory-side write (valid with request) |
| mem_addr_o | output | AW | Memory-side byte address |
| mem_wdata_o | output | 32 | Memory-side write data |
| mem_ack_i | input | 1 | Memory-side access done |
| mem_rdata_i | input | 32 | Memory-side read data |
| per_req_o | output | 1 | Peripheral-side access request |
| per_we_o | output | 1 | Peripheral-side write (valid with request) |
| per_addr_o | output | AW | Peripheral-side byte address |
| per_wdata_o | output | 32 | Peripheral-side write data |
| per_ack_i | input | 1 | Peripheral-side access done |
| per_rdata_i | input | 32 | Peripheral-side read data |
| irq_o | output | 1 | End-of-count interrupt |

## Verification
The hardest state to reach is a shadow write that lands in the middle of a running continuous pass, or between the two halves of a split buffer. The stimulus has to hit the window after the channel has latched the old values and before its reload point. The bench polls the status word until it sees the ping bit set, or a partly spent count, and only then rewrites the pointers and the count. A second write lands in the middle of a frozen interval. The reference model follows the same writes cycle by cycle, so a reload that comes one half early or one pass late shows up as a wrong address on the next request.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   localparam int unsigned DW = 32;

   // register indices
   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_STAT = 3'd1;
   localparam logic [2:0] A_MPTR = 3'd2;
   localparam logic [2:0] A_PPTR = 3'd3;
   localparam logic [2:0] A_MSEQ = 3'd4;
   localparam logic [2:0] A_PSEQ = 3'd5;

   // control word bit positions
   localparam int unsigned C_EN     = 31;
   localparam int unsigned C_IE     = 30;
   localparam int unsigned C_HOLD   = 29;
   localparam int unsigned C_DIR    = 28;
   localparam int unsigned C_ONCE   = 27;
   localparam int unsigned C_FLOW   = 21;
   localparam int unsigned C_SEL_LO = 16;
   localparam int unsigned C_CNT_LO = 2;

   // status word bit positions
   localparam int unsigned S_BUSY = 31;
   localparam int unsigned S_PEND = 30;
   localparam int unsigned S_HALT = 29;
   localparam int unsigned S_PING = 28;

   // memory sequence word: split (double buffer) select
   localparam int unsigned Q_SPLIT = 19;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RD   = 2'd1,
      PH_WR   = 2'd2
   } phase_t;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 14,
   parameter int unsigned SW = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_i,
   input  logic [2:0]    waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          pass_end_i,
   output logic          en_o,
   output logic          ie_o,
   output logic          hold_o,
   output logic          dir_o,
   output logic          once_o,
   output logic          flow_o,
   output logic [SW-1:0] sel_o,
   output logic [CW-1:0] cnt_o,
   output logic [CW-1:0] cnt_eff_o,
   output logic          start_o,
   output logic          stop_o,
   output logic          pend_o,
   output logic          split_o,
   output logic [AW-1:0] mptr_o,
   output logic [AW-1:0] pptr_o,
   output logic [DW-1:0] mseq_o,
   output logic [DW-1:0] pseq_o
);

   logic wr_ctrl, wr_stat, wr_mptr, wr_pptr, wr_mseq, wr_pseq;

   always_comb begin
      wr_ctrl = wr_i && (waddr_i == A_CTRL);
      wr_stat = wr_i && (waddr_i == A_STAT);
      wr_mptr = wr_i && (waddr_i == A_MPTR);
      wr_pptr = wr_i && (waddr_i == A_PPTR);
      wr_mseq = wr_i && (waddr_i == A_MSEQ);
      wr_pseq = wr_i && (waddr_i == A_PSEQ);
   end

   assign start_o   = wr_ctrl &&  wdata_i[C_EN] && !en_o;
   assign stop_o    = wr_ctrl && !wdata_i[C_EN] &&  en_o;
   assign cnt_eff_o = wr_ctrl ? wdata_i[C_CNT_LO +: CW] : cnt_o;
   assign split_o   = mseq_o[Q_SPLIT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_o   <= 1'b0;
         ie_o   <= 1'b0;
         hold_o <= 1'b0;
         dir_o  <= 1'b0;
         once_o <= 1'b0;
         flow_o <= 1'b0;
         sel_o  <= '0;
         cnt_o  <= '0;
      end else if (wr_ctrl) begin
         en_o   <= wdata_i[C_EN];
         ie_o   <= wdata_i[C_IE];
         hold_o <= wdata_i[C_HOLD];
         dir_o  <= wdata_i[C_DIR];
         once_o <= wdata_i[C_ONCE];
         flow_o <= wdata_i[C_FLOW];
         sel_o  <= wdata_i[C_SEL_LO +: SW];
         cnt_o  <= wdata_i[C_CNT_LO +: CW];
      end else if (pass_end_i && once_o) begin
         en_o   <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          pend_o <= 1'b0;
      else if (pass_end_i)                  pend_o <= 1'b1;
      else if (wr_stat && wdata_i[S_PEND])  pend_o <= 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mptr_o <= '0;
         pptr_o <= '0;
         mseq_o <= '0;
         pseq_o <= '0;
      end else begin
         if (wr_mptr) mptr_o <= {wdata_i[AW-1:2], 2'b00};
         if (wr_pptr) pptr_o <= {wdata_i[AW-1:2], 2'b00};
         if (wr_mseq) mseq_o <= wdata_i;
         if (wr_pseq) pseq_o <= wdata_i;
      end
   end

endmodule

// File: rtl/dma_chan_flow.sv
module dma_chan_flow #(
   parameter int unsigned NREQ     = 32,
   parameter int unsigned SW       = 5,
   parameter bit          HAS_FLOW = 1'b1
) (
   input  logic            flow_i,
   input  logic [SW-1:0]   sel_i,
   input  logic [NREQ-1:0] dreq_i,
   output logic            ok_o
);

   localparam int unsigned NEXT = 1 << SW;

   generate
      if (HAS_FLOW) begin : g_flow
         logic [NEXT-1:0] dreq_ext;
         always_comb begin
            dreq_ext             = '0;
            dreq_ext[NREQ-1:0]   = dreq_i;
            ok_o                 = !flow_i || dreq_ext[sel_i];
         end
      end else begin : g_free
         logic unused;
         assign unused = flow_i ^ (^sel_i) ^ (^dreq_i);
         assign ok_o   = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/dma_chan_mover.sv
module dma_chan_mover
   import dma_chan_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 14
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic          go_i,
   input  logic          src_ok_i,
   input  logic          once_i,
   input  logic          split_i,
   input  logic          dir_i,
   input  logic [AW-1:0] mptr_sh_i,
   input  logic [AW-1:0] pptr_sh_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          mem_ack_i,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          per_ack_i,
   input  logic [DW-1:0] per_rdata_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   output logic          per_req_o,
   output logic          per_we_o,
   output logic [AW-1:0] per_addr_o,
   output logic [DW-1:0] per_wdata_o,
   output logic          busy_o,
   output logic          ping_o,
   output logic [CW-1:0] rem_o,
   output logic          pass_end_o
);

   localparam logic [AW-1:0] STEP = AW'(4);

   phase_t        ph;
   logic [AW-1:0] ma, pa;
   logic [CW-1:0] lcnt;
   logic [DW-1:0] data_q;
   logic          src_req, dst_req, src_ack, dst_ack, beat_done;
   logic [DW-1:0] src_data;

   always_comb begin
      src_req    = go_i && (ph == PH_RD) && src_ok_i;
      dst_req    = go_i && (ph == PH_WR);
      src_ack    = dir_i ? mem_ack_i   : per_ack_i;
      dst_ack    = dir_i ? per_ack_i   : mem_ack_i;
      src_data   = dir_i ? mem_rdata_i : per_rdata_i;
      mem_req_o  = dir_i ? src_req : dst_req;
      per_req_o  = dir_i ? dst_req : src_req;
      mem_we_o   = !dir_i && dst_req;
      per_we_o   =  dir_i && dst_req;
      beat_done  = dst_req && dst_ack;
      pass_end_o = beat_done && (rem_o == '0);
   end

   assign mem_addr_o  = ma;
   assign per_addr_o  = pa;
   assign mem_wdata_o = data_q;
   assign per_wdata_o = data_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph     <= PH_IDLE;
         ma     <= '0;
         pa     <= '0;
         lcnt   <= '0;
         rem_o  <= '0;
         data_q <= '0;
         busy_o <= 1'b0;
         ping_o <= 1'b0;
      end else if (stop_i) begin
         ph     <= PH_IDLE;
         busy_o <= 1'b0;
         ping_o <= 1'b0;
      end else if (start_i) begin
         ph     <= PH_RD;
         busy_o <= 1'b1;
         ping_o <= 1'b0;
         ma     <= mptr_sh_i;
         pa     <= pptr_sh_i;
         rem_o  <= cnt_i;
         lcnt   <= cnt_i;
      end else if (src_req && src_ack) begin
         data_q <= src_data;
         ph     <= PH_WR;
      end else if (beat_done) begin
         ph <= PH_RD;
         if (rem_o != '0) begin
            rem_o <= rem_o - 1'b1;
            ma    <= ma + STEP;
            pa    <= pa + STEP;
         end else if (once_i) begin
            ph     <= PH_IDLE;
            busy_o <= 1'b0;
            ma     <= ma + STEP;
            pa     <= pa + STEP;
         end else if (split_i && !ping_o) begin
            ping_o <= 1'b1;
            rem_o  <= lcnt;
            ma     <= ma + STEP;
            pa     <= pa + STEP;
         end else begin
            ping_o <= 1'b0;
            ma     <= mptr_sh_i;
            pa     <= pptr_sh_i;
            rem_o  <= cnt_i;
            lcnt   <= cnt_i;
         end
      end
   end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
   import dma_chan_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned CW       = 14,
   parameter int unsigned NREQ     = 32,
   parameter bit          HAS_FLOW = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            reg_wr_i,
   input  logic [2:0]      reg_waddr_i,
   input  logic [31:0]     reg_wdata_i,
   input  logic [2:0]      reg_raddr_i,
   output logic [31:0]     reg_rdata_o,
   input  logic            gen_en_i,
   input  logic [NREQ-1:0] dreq_i,
   output logic            mem_req_o,
   output logic            mem_we_o,
   output logic [AW-1:0]   mem_addr_o,
   output logic [31:0]     mem_wdata_o,
   input  logic            mem_ack_i,
   input  logic [31:0]     mem_rdata_i,
   output logic            per_req_o,
   output logic            per_we_o,
   output logic [AW-1:0]   per_addr_o,
   output logic [31:0]     per_wdata_o,
   input  logic            per_ack_i,
   input  logic [31:0]     per_rdata_i,
   output logic            irq_o
);

   localparam int unsigned SW = (NREQ > 1) ? $clog2(NREQ) : 1;

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("dma_chan: AW must lie in 8..32");
      end
      if (CW < 1 || CW > 14) begin : g_bad_cw
         $error("dma_chan: CW must lie in 1..14");
      end
      if (NREQ < 2 || NREQ > 32) begin : g_bad_nreq
         $error("dma_chan: NREQ must lie in 2..32");
      end
   endgenerate

   logic          ctrl_en, ctrl_ie, ctrl_hold, ctrl_dir, ctrl_once, ctrl_flow;
   logic [SW-1:0] ctrl_sel;
   logic [CW-1:0] ctrl_cnt, cnt_eff, rem;
   logic          start, stop, pend, split, busy, ping, pass_end, src_ok;
   logic [AW-1:0] mptr_sh, pptr_sh;
   logic [31:0]   mseq, pseq;

   dma_chan_regs #(.AW(AW), .CW(CW), .SW(SW)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (reg_wr_i),
      .waddr_i    (reg_waddr_i),
      .wdata_i    (reg_wdata_i),
      .pass_end_i (pass_end),
      .en_o       (ctrl_en),
      .ie_o       (ctrl_ie),
      .hold_o     (ctrl_hold),
      .dir_o      (ctrl_dir),
      .once_o     (ctrl_once),
      .flow_o     (ctrl_flow),
      .sel_o      (ctrl_sel),
      .cnt_o      (ctrl_cnt),
      .cnt_eff_o  (cnt_eff),
      .start_o    (start),
      .stop_o     (stop),
      .pend_o     (pend),
      .split_o    (split),
      .mptr_o     (mptr_sh),
      .pptr_o     (pptr_sh),
      .mseq_o     (mseq),
      .pseq_o     (pseq)
   );

   dma_chan_flow #(.NREQ(NREQ), .SW(SW), .HAS_FLOW(HAS_FLOW)) u_flow (
      .flow_i (ctrl_flow),
      .sel_i  (ctrl_sel),
      .dreq_i (dreq_i),
      .ok_o   (src_ok)
   );

   dma_chan_mover #(.AW(AW), .CW(CW)) u_mover (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start),
      .stop_i      (stop),
      .go_i        (gen_en_i),
      .src_ok_i    (src_ok),
      .once_i      (ctrl_once),
      .split_i     (split),
      .dir_i       (ctrl_dir),
      .mptr_sh_i   (mptr_sh),
      .pptr_sh_i   (pptr_sh),
      .cnt_i       (cnt_eff),
      .mem_ack_i   (mem_ack_i),
      .mem_rdata_i (mem_rdata_i),
      .per_ack_i   (per_ack_i),
      .per_rdata_i (per_rdata_i),
      .mem_req_o   (mem_req_o),
      .mem_we_o    (mem_we_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .per_req_o   (per_req_o),
      .per_we_o    (per_we_o),
      .per_addr_o  (per_addr_o),
      .per_wdata_o (per_wdata_o),
      .busy_o      (busy),
      .ping_o      (ping),
      .rem_o       (rem),
      .pass_end_o  (pass_end)
   );

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_raddr_i)
         A_CTRL: begin
            reg_rdata_o[C_EN]              = ctrl_en;
            reg_rdata_o[C_IE]              = ctrl_ie;
            reg_rdata_o[C_HOLD]            = ctrl_hold;
            reg_rdata_o[C_DIR]             = ctrl_dir;
            reg_rdata_o[C_ONCE]            = ctrl_once;
            reg_rdata_o[C_FLOW]            = ctrl_flow;
            reg_rdata_o[C_SEL_LO +: SW]    = ctrl_sel;
            reg_rdata_o[C_CNT_LO +: CW]    = ctrl_cnt;
         end
         A_STAT: begin
            reg_rdata_o[S_BUSY]            = busy;
            reg_rdata_o[S_PEND]            = pend;
            reg_rdata_o[S_HALT]            = busy && !gen_en_i;
            reg_rdata_o[S_PING]            = ping;
            reg_rdata_o[C_CNT_LO +: CW]    = rem;
         end
         A_MPTR:  reg_rdata_o[AW-1:0] = mptr_sh;
         A_PPTR:  reg_rdata_o[AW-1:0] = pptr_sh;
         A_MSEQ:  reg_rdata_o = mseq;
         A_PSEQ:  reg_rdata_o = pseq;
         default: reg_rdata_o = '0;
      endcase
   end

   assign irq_o = pend && ctrl_ie;

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 14
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          reg_wr_i,
   input logic          gen_en_i,
   input logic          mem_req_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          per_req_o,
   input logic [AW-1:0] per_addr_o,
   input logic          irq_o,
   input logic          busy,
   input logic          pend,
   input logic          ctrl_ie,
   input logic [CW-1:0] rem
);

   // R1: the two sides are never requested together
   a_r1_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mem_req_o && per_req_o));

   // R8: no requests while frozen
   a_r8_no_req_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gen_en_i |-> (!mem_req_o && !per_req_o));

   // R8: remaining count holds while frozen and untouched by software
   a_r8_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gen_en_i && !reg_wr_i) |=> $stable(rem));

   // R5: interrupt only with pending and enable
   a_r5_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (pend && ctrl_ie));

   // R10: issued addresses are word aligned
   a_r10_mem_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
   a_r10_per_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
      per_req_o |-> (per_addr_o[1:0] == 2'b00));

   // R3: busy dropping without a software write means a pass just ended
   a_r3_self_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(busy) && !$past(reg_wr_i)) |-> pend);

endmodule

bind dma_chan dma_chan_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .reg_wr_i   (reg_wr_i),
   .gen_en_i   (gen_en_i),
   .mem_req_o  (mem_req_o),
   .mem_addr_o (mem_addr_o),
   .per_req_o  (per_req_o),
   .per_addr_o (per_addr_o),
   .irq_o      (irq_o),
   .busy       (busy),
   .pend       (pend),
   .ctrl_ie    (ctrl_ie),
   .rem        (rem)
);

// File: tb/tb_dma_chan.sv
`timescale 1ns/1ps
module tb_dma_chan;

   localparam logic [31:0] MKEY = 32'h5A00_0000;
   localparam logic [31:0] PKEY = 32'h00C3_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [2:0]  waddr = '0;
   logic [31:0] wdata = '0;
   logic [2:0]  raddr = 3'd1;
   logic [31:0] rdata;
   logic        gen_en = 1'b1;
   logic [31:0] dreq = '0;
   logic        mem_req, mem_we, per_req, per_we, irq;
   logic [31:0] mem_addr, mem_wdata, per_addr, per_wdata;
   logic [31:0] mem_rdata, per_rdata;
   logic        mem_ack = 1'b1;
   logic        per_ack = 1'b1;

   int vectors = 0;
   int errors  = 0;
   int cyc     = 0;
   bit done    = 0;

   always #5 clk = ~clk;

   assign mem_rdata = mem_addr ^ MKEY;
   assign per_rdata = per_addr ^ PKEY;

   dma_chan dut (
      .clk_i(clk), .rst_ni(rst_n),
      .reg_wr_i(wr), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
      .reg_raddr_i(raddr), .reg_rdata_o(rdata),
      .gen_en_i(gen_en), .dreq_i(dreq),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
      .per_req_o(per_req), .per_we_o(per_we), .per_addr_o(per_addr),
      .per_wdata_o(per_wdata), .per_ack_i(per_ack), .per_rdata_i(per_rdata),
      .irq_o(irq)
   );

   // ---------------- reference model ----------------
   bit m_en, m_ie, m_hold, m_dir, m_once, m_flow, m_busy, m_pend, m_ping, m_dbl;
   int m_rsel, m_wcnt, m_rem, m_lc, m_ph;
   logic [31:0] m_ma, m_pa, m_msh, m_psh, m_mseq, m_pseq, m_data;

   task automatic model_reset();
      m_en = 0; m_ie = 0; m_hold = 0; m_dir = 0; m_once = 0; m_flow = 0;
      m_busy = 0; m_pend = 0; m_ping = 0; m_dbl = 0;
      m_rsel = 0; m_wcnt = 0; m_rem = 0; m_lc = 0; m_ph = 0;
      m_ma = 0; m_pa = 0; m_msh = 0; m_psh = 0; m_mseq = 0; m_pseq = 0; m_data = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit wc, st, sp, pe;
         int nc;
         wc = wr && waddr == 3'd0;
         st = wc && wdata[31] && !m_en;
         sp = wc && !wdata[31] && m_en;
         nc = wc ? int'(wdata[15:2]) : m_wcnt;
         pe = (m_ph == 2) && gen_en && (m_rem == 0);
         if (sp) begin
            m_busy = 0; m_ph = 0; m_ping = 0;
         end else if (st) begin
            m_busy = 1; m_ph = 1; m_ping = 0;
            m_ma = m_msh; m_pa = m_psh; m_rem = nc; m_lc = nc;
         end else if (gen_en) begin
            if (m_ph == 1 && (!m_flow || dreq[m_rsel])) begin
               m_data = m_dir ? (m_ma ^ MKEY) : (m_pa ^ PKEY);
               m_ph = 2;
            end else if (m_ph == 2) begin
               m_ma += 4; m_pa += 4; m_ph = 1;
               if (m_rem != 0) m_rem--;
               else if (m_once) begin m_busy = 0; m_ph = 0; end
               else if (m_dbl && !m_ping) begin m_ping = 1; m_rem = m_lc; end
               else begin
                  m_ping = 0; m_ma = m_msh; m_pa = m_psh; m_rem = nc; m_lc = nc;
               end
            end
         end
         if (pe) m_pend = 1;
         else if (wr && waddr == 3'd1 && wdata[30]) m_pend = 0;
         if (wc) begin
            m_en = wdata[31]; m_ie = wdata[30]; m_hold = wdata[29]; m_dir = wdata[28];
            m_once = wdata[27]; m_flow = wdata[21]; m_rsel = int'(wdata[20:16]);
            m_wcnt = int'(wdata[15:2]);
         end else if (pe && m_once) m_en = 0;
         if (wr && waddr == 3'd2) m_msh = {wdata[31:2], 2'b00};
         if (wr && waddr == 3'd3) m_psh = {wdata[31:2], 2'b00};
         if (wr && waddr == 3'd4) begin m_mseq = wdata; m_dbl = wdata[19]; end
         if (wr && waddr == 3'd5) m_pseq = wdata;
      end
   end

   task automatic fail(string tag, logic [31:0] act, logic [31:0] exp);
      errors++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) fail(tag, act, exp);
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit ok, e_src, e_dst, e_mreq, e_preq;
         logic [31:0] e_rd;
         vectors++;
         ok = !m_flow || dreq[m_rsel];
         e_src = gen_en && m_ph == 1 && ok;
         e_dst = gen_en && m_ph == 2;
         e_mreq = m_dir ? e_src : e_dst;
         e_preq = m_dir ? e_dst : e_src;
         if (mem_req !== e_mreq) fail("R1 mem_req", 32'(mem_req), 32'(e_mreq));
         if (per_req !== e_preq) fail("R1 per_req", 32'(per_req), 32'(e_preq));
         if (e_mreq && mem_addr !== m_ma) fail("R1 mem_addr", mem_addr, m_ma);
         if (e_preq && per_addr !== m_pa) fail("R1 per_addr", per_addr, m_pa);
         if (e_mreq && mem_we !== e_dst) fail("R1 mem_we", 32'(mem_we), 32'(e_dst));
         if (e_preq && per_we !== e_dst) fail("R1 per_we", 32'(per_we), 32'(e_dst));
         if (e_dst && !m_dir && mem_wdata !== m_data) fail("R1 mem_wdata", mem_wdata, m_data);
         if (e_dst && m_dir && per_wdata !== m_data) fail("R1 per_wdata", per_wdata, m_data);
         if (irq !== (m_pend && m_ie)) fail("R5 irq", 32'(irq), 32'(m_pend && m_ie));
         case (raddr)
            3'd0: begin
               e_rd = {m_en, m_ie, m_hold, m_dir, m_once, 5'b0, m_flow, 5'(m_rsel),
                       14'(m_wcnt), 2'b00};
               if (rdata !== e_rd) fail("R3 ctrl readback", rdata, e_rd);
            end
            3'd1: begin
               if (rdata[31] !== m_busy) fail("R3 busy", 32'(rdata[31]), 32'(m_busy));
               if (rdata[30] !== m_pend) fail("R4 pending", 32'(rdata[30]), 32'(m_pend));
               if (rdata[29] !== (m_busy && !gen_en))
                  fail("R8 halted", 32'(rdata[29]), 32'(m_busy && !gen_en));
               if (rdata[28] !== m_ping) fail("R7 ping", 32'(rdata[28]), 32'(m_ping));
               if (rdata[15:2] !== 14'(m_rem)) fail("R2 remaining", 32'(rdata[15:2]), 32'(m_rem));
            end
            3'd2: if (rdata !== m_msh) fail("R10 mem ptr", rdata, m_msh);
            3'd3: if (rdata !== m_psh) fail("R10 per ptr", rdata, m_psh);
            3'd4: if (rdata !== m_mseq) fail("R7 mem seq", rdata, m_mseq);
            3'd5: if (rdata !== m_pseq) fail("R12 per seq", rdata, m_pseq);
            default: if (rdata !== 32'h0) fail("R12 unused", rdata, 32'h0);
         endcase
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic wreg(logic [2:0] a, logic [31:0] d);
      @(negedge clk); #1;
      wr = 1'b1; waddr = a; wdata = d;
      @(negedge clk); #1;
      wr = 1'b0;
   endtask

   task automatic rsel(logic [2:0] a);
      @(negedge clk); #1;
      raddr = a;
      @(negedge clk); #1;
   endtask

   task automatic wait_status(int bitpos, bit val);
      raddr = 3'd1;
      for (int i = 0; i < 400 && rdata[bitpos] !== val; i++) @(negedge clk);
      #1;
   endtask

   task automatic summary();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual cycles=%0d expected fewer", cyc);
         summary();
      end
   end

   // ---------------- test sequence ----------------
   initial begin
      logic [31:0] snap;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R12: reset state
      chk("R12 status after reset", rdata, 32'h0);
      chk("R12 irq after reset", 32'(irq), 32'h0);
      chk("R12 requests after reset", 32'({mem_req, per_req}), 32'h0);
      rsel(3'd0);
      chk("R12 ctrl after reset", rdata, 32'h0);

      // R10: alignment of pointer writes
      wreg(3'd2, 32'h1000_0003);
      wreg(3'd3, 32'h2000_0001);
      rsel(3'd2);
      chk("R10 mem ptr low bits", rdata, 32'h1000_0000);
      rsel(3'd3);
      chk("R10 per ptr low bits", rdata, 32'h2000_0000);

      // R1 R2 R3: run-once, memory to peripheral, 4 words
      raddr = 3'd1;
      wreg(3'd0, 32'hD800_000C);
      wait_status(31, 1'b0);
      step(1);
      chk("R3 busy low after run-once", 32'(rdata[31]), 32'h0);
      chk("R4 pending after pass", 32'(rdata[30]), 32'h1);
      chk("R5 irq with enable", 32'(irq), 32'h1);
      rsel(3'd0);
      chk("R3 enable bit self-cleared", 32'(rdata[31]), 32'h0);
      raddr = 3'd1;
      wreg(3'd1, 32'h4000_0000);
      chk("R4 pending cleared by write-one", 32'(rdata[30]), 32'h0);

      // R9: flow control, peripheral to memory, run-once, 3 words, line 5
      wreg(3'd2, 32'h0000_3000);
      wreg(3'd3, 32'h0000_4000);
      dreq = 32'hFFFF_FFDF;
      wreg(3'd0, 32'h8825_0008);
      step(6);
      chk("R9 no read without selected line", 32'(per_req), 32'h0);
      chk("R9 count held without request", 32'(rdata[15:2]), 32'd2);
      for (int i = 0; i < 60 && rdata[31]; i++) begin
         dreq = (i % 3 != 0) ? 32'h0000_0020 : 32'hFFFF_FFDF;
         step(1);
      end
      dreq = '0;
      step(1);
      chk("R9 pass done under flow control", 32'(rdata[31]), 32'h0);
      wreg(3'd1, 32'h4000_0000);

      // R6: continuous single buffer, mid-run shadow writes
      wreg(3'd2, 32'h0000_5000);
      wreg(3'd3, 32'h0000_6000);
      wreg(3'd0, 32'h9000_0004);
      step(2);
      wreg(3'd2, 32'h0000_7000);
      wreg(3'd3, 32'h0000_8000);
      wreg(3'd0, 32'h9000_0008);
      step(20);
      // R8: freeze
      gen_en = 1'b0;
      step(1);
      snap = rdata;
      chk("R8 halted flag", 32'(rdata[29]), 32'h1);
      wreg(3'd2, 32'h0000_9000);
      step(5);
      chk("R8 count frozen", 32'(rdata[15:2]), 32'(snap[15:2]));
      chk("R8 no requests frozen", 32'({mem_req, per_req}), 32'h0);
      gen_en = 1'b1;
      step(16);
      // R11: stop
      wreg(3'd0, 32'h1000_0008);
      chk("R11 busy low after stop", 32'(rdata[31]), 32'h0);
      step(3);
      chk("R11 no requests after stop", 32'({mem_req, per_req}), 32'h0);
      wreg(3'd1, 32'h4000_0000);

      // R7: split buffer mode
      wreg(3'd4, 32'h0008_0000);
      wreg(3'd2, 32'h0000_A000);
      wreg(3'd3, 32'h0000_B000);
      wreg(3'd0, 32'hD000_0004);
      wait_status(28, 1'b1);
      chk("R7 pending at half", 32'(rdata[30]), 32'h1);
      chk("R7 ping in second half", 32'(rdata[28]), 32'h1);
      wreg(3'd2, 32'h0000_C000);
      wreg(3'd3, 32'h0000_D000);
      wreg(3'd1, 32'h4000_0000);
      wait_status(28, 1'b0);
      chk("R7 ping back after full buffer", 32'(rdata[28]), 32'h0);
      step(24);
      rsel(3'd4);
      step(2);
      raddr = 3'd1;
      wreg(3'd0, 32'h0000_0000);
      step(3);
      chk("R11 split stop busy", 32'(rdata[31]), 32'h0);
      chk("R11 split stop ping", 32'(rdata[28]), 32'h0);
      summary();
   end

endmodule